// File: doc/BRIEF.md
# Serial Transmitter with Break and Idle-Preamble Generation

This block is the transmit half of an asynchronous serial port, driven through a small register bus. Software places a character in a one-word holding register. A shift register moves it onto the `txd` line, one bit for each strobe on `bit_tick`. The block decides what to send at each character boundary, in this order: a break (a run of zeros), then an idle preamble (a run of ones), then held data.

Two status flags describe the transmitter. The holding-register-empty flag shows that a new character can be written. The line-done flag shows that nothing is queued or being shifted. Both flags are cleared only by an ordered pair of accesses: first a status read while the flag is set, then a write to the data-low register.

The bit-rate divider is outside this block. It supplies `bit_tick`, a one-clock strobe that marks each bit period.

Register map:

| Address | Contents |
|---------|----------|
| 0 | Control. Bit 0 enables the transmitter. Bit 1 requests a break. Bit 2 selects long break. Bit 3 selects 9-bit data. |
| 1 | Status. Bit 7 is the holding-register-empty flag. Bit 6 is the line-done flag. |
| 2 | Data high. Bit 0 is the ninth data bit. |
| 3 | Data low. The low eight data bits. |

Top module: `uart_brk_tx`

## Requirements
- R1: After reset, `txd` is 1, the control register (address 0) reads 0, and status bits 7 (empty) and 6 (done) both read 1.
- R2: A data character is sent as follows, with each bit lasting one `bit_tick` period:
  - first a 0 start bit;
  - then the data bits, least significant first: 8 bits, or 9 when control bit 3 is set, with the ninth bit taken from address 2 bit 0;
  - then a 1 stop bit.
- R3: The empty flag rises when the shift register takes the held character. A character written while another is being shifted follows it with no idle bit between them.
- R4: A flag clears only when two things happen in order: a status read at address 1 while that flag is 1, and then a write to address 3. A write to address 3 with no such read leaves both flags at 1 and leaves the line idle.
- R5: The done flag stays 0 while any character is queued or being shifted. It rises at the first bit boundary where nothing is left to send and the empty flag is 1. While the done flag is 1, `txd` is 1.
- R6: Changing control bit 0 from 0 to 1 queues an idle preamble of ones, as long as one character frame (10 bits, or 11 in 9-bit mode). This write clears the done flag. The done flag rises at the 11th `bit_tick` after the write (the 12th in 9-bit mode).
- R7: A break is a run of zeros whose length depends on two control bits:
  - 10 bits in 8-bit mode, or 11 in 9-bit mode;
  - 3 bits longer when control bit 2 is set.
- R8: Setting control bit 1 and clearing it again before the break begins sends exactly one complete break.
- R9: While control bit 1 stays set, complete breaks follow one another. When the bit is cleared, the break in progress still finishes, so the total zero run is a whole multiple of the break length.
- R10: At a character boundary, a pending break is sent before held data.
- R11: If the done flag is set and cleared in the same cycle, the clear wins and the flag reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block. |
| bit_tick | input | 1 | One-cycle strobe marking each bit period |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| txd | output | 1 | Serial output line |

## Verification
The bound checker tests four rules on every cycle:
- the line is high whenever the done flag is set;
- the empty flag rises only after the shifter takes a character, and falls only after a data-low write;
- a same-cycle set and clear of the done flag leaves it at 0;
- the bit counter never exceeds the longest break.

Bit-exact frame and break contents, preamble length and the single-toggle behaviour of the break bit depend on the history of ticks and register writes. These can only be shown by the bench's scenarios, which capture `txd` on every tick and compare it with sequences built from the requirements.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

  // register addresses
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_STAT = 1;
  localparam int unsigned A_DHI  = 2;
  localparam int unsigned A_DLO  = 3;

  // status bit positions
  localparam int unsigned SB_EMPTY = 7;
  localparam int unsigned SB_DONE  = 6;

  // control register, bit 0 = enable
  typedef struct packed {
    logic nine;
    logic lng;
    logic brk;
    logic en;
  } ctrl_t;

  typedef enum logic [1:0] {CH_NONE, CH_BRK, CH_PRE, CH_DAT} char_kind_e;

  function automatic int unsigned frame_bits(int unsigned dw, logic nine);
    return dw + 2 + (nine ? 1 : 0);
  endfunction

  function automatic int unsigned break_bits(int unsigned dw, logic nine, logic lng);
    return frame_bits(dw, nine) + (lng ? 3 : 0);
  endfunction

endpackage

// File: rtl/uart_brk_rstsync.sv
module uart_brk_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/uart_brk_regs.sv
module uart_brk_regs
  import uart_brk_pkg::*;
#(
  parameter int unsigned AW = 2,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          take_brk,
  input  logic          take_pre,
  input  logic          take_dat,
  input  logic          tc_set,
  output ctrl_t         ctrl,
  output logic [DW:0]   tdr,
  output logic          tdre,
  output logic          tc,
  output logic          brk_pend,
  output logic          pre_pend,
  output logic          tc_clr,
  output logic [DW-1:0] bus_rdata
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  ctrl_t       ctrl_q, ctrl_n;
  logic [DW:0] tdr_q, tdr_n;
  logic        tdre_q, tdre_n, tc_q, tc_n;
  logic        arm_e_q, arm_e_n, arm_d_q, arm_d_n;
  logic        brk_q, brk_n, pre_q, pre_n;
  logic        wr_ctrl, wr_dhi, wr_dlo, rd_stat;
  logic        brk_rise, en_rise, queue_ev;

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == AW'(A_CTRL));
    wr_dhi   = bus_wr && (bus_addr == AW'(A_DHI));
    wr_dlo   = bus_wr && (bus_addr == AW'(A_DLO));
    rd_stat  = bus_rd && (bus_addr == AW'(A_STAT));
    brk_rise = wr_ctrl && bus_wdata[1] && !ctrl_q.brk;
    en_rise  = wr_ctrl && bus_wdata[0] && !ctrl_q.en;
    queue_ev = brk_rise || en_rise;

    ctrl_n = wr_ctrl ? ctrl_t'(bus_wdata[CTRL_W-1:0]) : ctrl_q;

    tdr_n = tdr_q;
    if (wr_dlo) tdr_n[DW-1:0] = bus_wdata;
    if (wr_dhi) tdr_n[DW]     = bus_wdata[0];

    // arming by status read, disarming by data-low write
    arm_e_n = wr_dlo ? 1'b0 : ((rd_stat && tdre_q) ? 1'b1 : arm_e_q);
    arm_d_n = wr_dlo ? 1'b0 : ((rd_stat && tc_q)   ? 1'b1 : arm_d_q);

    if (take_dat)                tdre_n = 1'b1;
    else if (wr_dlo && arm_e_q)  tdre_n = 1'b0;
    else                         tdre_n = tdre_q;

    // clear has priority over set
    tc_clr = (wr_dlo && arm_d_q) || queue_ev || take_brk || take_pre || take_dat;
    if (tc_clr)      tc_n = 1'b0;
    else if (tc_set) tc_n = 1'b1;
    else             tc_n = tc_q;

    if (brk_rise)      brk_n = 1'b1;
    else if (take_brk) brk_n = 1'b0;
    else               brk_n = brk_q;

    if (en_rise)                          pre_n = 1'b1;
    else if (take_pre)                    pre_n = 1'b0;
    else if (wr_ctrl && !bus_wdata[0])    pre_n = 1'b0;
    else                                  pre_n = pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      tdr_q   <= '0;
      tdre_q  <= 1'b1;
      tc_q    <= 1'b1;
      arm_e_q <= 1'b0;
      arm_d_q <= 1'b0;
      brk_q   <= 1'b0;
      pre_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_n;
      tdr_q   <= tdr_n;
      tdre_q  <= tdre_n;
      tc_q    <= tc_n;
      arm_e_q <= arm_e_n;
      arm_d_q <= arm_d_n;
      brk_q   <= brk_n;
      pre_q   <= pre_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(A_CTRL): bus_rdata[CTRL_W-1:0] = ctrl_q;
      AW'(A_STAT): begin
        bus_rdata[SB_EMPTY] = tdre_q;
        bus_rdata[SB_DONE]  = tc_q;
      end
      AW'(A_DHI):  bus_rdata[0] = tdr_q[DW];
      default:     bus_rdata = tdr_q[DW-1:0];
    endcase
  end

  assign ctrl     = ctrl_q;
  assign tdr      = tdr_q;
  assign tdre     = tdre_q;
  assign tc       = tc_q;
  assign brk_pend = brk_q;
  assign pre_pend = pre_q;
endmodule

// File: rtl/uart_brk_shift.sv
module uart_brk_shift
  import uart_brk_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_tick,
  input  ctrl_t                      ctrl,
  input  logic [DW:0]                tdr,
  input  logic                       tdre,
  input  logic                       brk_pend,
  input  logic                       pre_pend,
  output logic                       txd,
  output logic                       take_brk,
  output logic                       take_pre,
  output logic                       take_dat,
  output logic                       tc_set,
  output logic [$clog2(DW+7)-1:0]    left
);
  localparam int unsigned SW = DW + 5;
  localparam int unsigned CW = $clog2(DW + 7);

  logic [SW-1:0] sh_q, sh_n;
  logic [CW-1:0] left_q, left_n;
  logic          txd_q, txd_n;
  char_kind_e    kind;
  logic          at_bound, load;

  // character selection at a boundary: break, preamble, data
  always_comb begin
    at_bound = bit_tick && (left_q == '0);
    if (!ctrl.en)                    kind = CH_NONE;
    else if (brk_pend || ctrl.brk)   kind = CH_BRK;
    else if (pre_pend)               kind = CH_PRE;
    else if (!tdre)                  kind = CH_DAT;
    else                             kind = CH_NONE;
    load = at_bound && (kind != CH_NONE);
  end

  always_comb begin
    sh_n   = sh_q;
    left_n = left_q;
    txd_n  = txd_q;
    if (load) begin
      unique case (kind)
        CH_BRK: begin
          txd_n  = 1'b0;
          sh_n   = '0;
          left_n = CW'(break_bits(DW, ctrl.nine, ctrl.lng) - 1);
        end
        CH_PRE: begin
          txd_n  = 1'b1;
          sh_n   = '1;
          left_n = CW'(frame_bits(DW, ctrl.nine) - 1);
        end
        CH_DAT: begin
          txd_n          = 1'b0;
          sh_n           = '1;
          sh_n[DW-1:0]   = tdr[DW-1:0];
          if (ctrl.nine) sh_n[DW] = tdr[DW];
          left_n = CW'(frame_bits(DW, ctrl.nine) - 1);
        end
        default: ;
      endcase
    end else if (bit_tick && (left_q != '0)) begin
      txd_n  = sh_q[0];
      sh_n   = {1'b1, sh_q[SW-1:1]};
      left_n = left_q - 1'b1;
    end else if (at_bound) begin
      txd_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      txd_q  <= 1'b1;
    end else if (bit_tick) begin
      sh_q   <= sh_n;
      left_q <= left_n;
      txd_q  <= txd_n;
    end
  end

  assign take_brk = load && (kind == CH_BRK);
  assign take_pre = load && (kind == CH_PRE);
  assign take_dat = load && (kind == CH_DAT);
  assign tc_set   = at_bound && !load && tdre;
  assign txd      = txd_q;
  assign left     = left_q;
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
  import uart_brk_pkg::*;
#(
  parameter int unsigned AW          = 2,
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          txd
);
  localparam int unsigned CW = $clog2(DW + 7);

  logic          rst_sync_n;
  ctrl_t         ctrl_w;
  logic [DW:0]   tdr_w;
  logic          tdre_w, tc_w, brk_pend_w, pre_pend_w, tc_clr_w;
  logic          take_brk_w, take_pre_w, take_dat_w, tc_set_w;
  logic [CW-1:0] left_w;

  uart_brk_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  uart_brk_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .take_brk  (take_brk_w),
    .take_pre  (take_pre_w),
    .take_dat  (take_dat_w),
    .tc_set    (tc_set_w),
    .ctrl      (ctrl_w),
    .tdr       (tdr_w),
    .tdre      (tdre_w),
    .tc        (tc_w),
    .brk_pend  (brk_pend_w),
    .pre_pend  (pre_pend_w),
    .tc_clr    (tc_clr_w),
    .bus_rdata (bus_rdata)
  );

  uart_brk_shift #(.DW(DW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bit_tick (bit_tick),
    .ctrl     (ctrl_w),
    .tdr      (tdr_w),
    .tdre     (tdre_w),
    .brk_pend (brk_pend_w),
    .pre_pend (pre_pend_w),
    .txd      (txd),
    .take_brk (take_brk_w),
    .take_pre (take_pre_w),
    .take_dat (take_dat_w),
    .tc_set   (tc_set_w),
    .left     (left_w)
  );
endmodule

// File: rtl/uart_brk_chk.sv
module uart_brk_chk
  import uart_brk_pkg::*;
#(
  parameter int unsigned AW = 2,
  parameter int unsigned DW = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    txd,
  input logic                    tdre,
  input logic                    tc,
  input logic                    tc_set,
  input logic                    tc_clr,
  input logic                    take_dat,
  input logic                    bus_wr,
  input logic [AW-1:0]           bus_addr,
  input logic [$clog2(DW+7)-1:0] left
);
  localparam int unsigned MAXLEFT = DW + 5;

  a_r5_done_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> txd);

  a_r11_clear_beats_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_set && tc_clr) |=> !tc);

  a_r3_empty_rise_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tdre) |-> $past(take_dat));

  a_r4_empty_fall_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tdre) |-> $past(bus_wr && (bus_addr == AW'(A_DLO))));

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    left <= ($clog2(DW+7))'(MAXLEFT));
endmodule

bind uart_brk_tx uart_brk_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .txd      (txd),
  .tdre     (tdre_w),
  .tc       (tc_w),
  .tc_set   (tc_set_w),
  .tc_clr   (tc_clr_w),
  .take_dat (take_dat_w),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .left     (left_w)
);

// File: tb/sim_uart_brk_tx.sv
module sim_uart_brk_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  wire  [7:0] bus_rdata;
  wire        txd;

  always #4 clk = ~clk;

  uart_brk_tx u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txd(txd)
  );

  int   tick_div = 0, ticks = 0, cap_n = 0, exp_n = 0, n_chk = 0, n_err = 0;
  logic cap  [0:511];
  logic expv [0:511];

  always @(negedge clk) begin
    if (!rst_n) begin
      tick_div <= 0;
      bit_tick <= 1'b0;
    end else begin
      tick_div <= (tick_div == 3) ? 0 : tick_div + 1;
      bit_tick <= (tick_div == 2);
    end
  end

  always @(negedge clk) begin
    if (bit_tick) begin
      ticks = ticks + 1;
      if (cap_n < 512) cap[cap_n] = txd;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    int t;
    t = ticks;
    while (ticks < t + n) @(negedge clk);
  endtask

  task automatic align();
    @(posedge clk iff bit_tick);
    @(negedge clk);
  endtask

  function automatic int flen(input logic nine);
    return nine ? 11 : 10;
  endfunction

  function automatic int blen(input logic nine, input logic lng);
    return flen(nine) + (lng ? 3 : 0);
  endfunction

  task automatic push_bit(input logic b);
    expv[exp_n] = b;
    exp_n++;
  endtask

  task automatic push_frame(input logic nine, input logic [8:0] d);
    push_bit(1'b0);
    for (int i = 0; i < (nine ? 9 : 8); i++) push_bit(d[i]);
    push_bit(1'b1);
  endtask

  task automatic push_zeros(input int n);
    for (int i = 0; i < n; i++) push_bit(1'b0);
  endtask

  task automatic cmp_cap(input string req);
    int f, bad;
    f = -1; bad = -1;
    for (int i = 0; i < cap_n && i < 512; i++) if (f < 0 && cap[i] == 1'b0) f = i;
    if (f < 0) begin
      chk(1'b0, req, -1, 0);
      return;
    end
    for (int i = 0; i < exp_n; i++)
      if (bad < 0 && (f + i >= cap_n || cap[f+i] !== expv[i])) bad = i;
    if (bad < 0 && (f + exp_n >= cap_n || cap[f+exp_n] !== 1'b1)) bad = exp_n;
    chk(bad < 0, {req, " (first mismatching bit index)"}, bad, -1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [8:0] dv, d2;
    logic       nine, lng;
    int         t0, z, f, seed_dummy;
    seed_dummy = $urandom(32'd7341);

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    chk(txd === 1'b1, "R1 line after reset", int'(txd), 1);
    rd(2'd0, d);
    chk(d == 8'h00, "R1 control after reset", d, 0);
    rd(2'd1, d);
    chk(d[7:6] == 2'b11, "R1 status after reset", d[7:6], 3);

    // R6 preamble in 8-bit mode
    align();
    wr(2'd0, 8'h01);
    t0 = ticks;
    rd(2'd1, d);
    chk(d[6] == 1'b0, "R6 done flag cleared on preamble queue", d[6], 0);
    do rd(2'd1, d); while (!d[6] && ticks < t0 + 40);
    chk(ticks - t0 == 11, "R6 preamble length 8-bit", ticks - t0, 11);

    // R2 R3 R5 random frames, alternating single and back-to-back
    for (int it = 0; it < 16; it++) begin
      nine = 1'($urandom % 2);
      dv   = 9'($urandom % 512);
      d2   = 9'($urandom % 512);
      wr(2'd0, {4'b0, nine, 3'b001});
      wr(2'd2, {7'b0, dv[8]});
      cap_n = 0; exp_n = 0;
      push_frame(nine, dv);
      rd(2'd1, d);
      wr(2'd3, dv[7:0]);
      rd(2'd1, d);
      chk(d[7:6] == 2'b00, "R4 flags cleared by read-then-write", d[7:6], 0);
      if (it % 2 == 1) begin
        wait_ticks(2);
        rd(2'd1, d);
        chk(d[7] == 1'b1, "R3 empty flag set once shifter takes data", d[7], 1);
        chk(d[6] == 1'b0, "R5 done flag low during frame", d[6], 0);
        wr(2'd2, {7'b0, d2[8]});
        wr(2'd3, d2[7:0]);
        push_frame(nine, d2);
      end
      wait_ticks(28);
      cmp_cap(it % 2 == 1 ? "R3 back-to-back frames" : "R2 frame bits");
      rd(2'd1, d);
      chk(d[7:6] == 2'b11, "R5 flags set when idle", d[7:6], 3);
    end

    // R4 data-low write without a preceding status read
    wr(2'd0, 8'h01);
    rd(2'd1, d);
    wr(2'd3, 8'h5A);
    wait_ticks(14);
    cap_n = 0;
    wr(2'd3, 8'hC3);
    wait_ticks(14);
    z = 0;
    for (int i = 0; i < cap_n && i < 512; i++) if (cap[i] == 1'b0) z++;
    chk(z == 0, "R4 unarmed write sends nothing", z, 0);
    rd(2'd1, d);
    chk(d[7:6] == 2'b11, "R4 unarmed write keeps flags", d[7:6], 3);

    // R11 set and clear of done flag in the same cycle
    rd(2'd1, d);
    @(posedge clk iff tick_div == 2);
    @(negedge clk);
    wr(2'd3, 8'h3C);
    rd(2'd1, d);
    chk(d[6] == 1'b0, "R11 clear wins over set", d[6], 0);
    wait_ticks(14);

    // R7 R8 single toggle, all length combinations
    for (int m = 0; m < 4; m++) begin
      nine = 1'(m % 2);
      lng  = 1'(m / 2);
      wr(2'd0, {4'b0, nine, lng, 2'b01});
      wait_ticks(2);
      cap_n = 0; exp_n = 0;
      push_zeros(blen(nine, lng));
      wr(2'd0, {4'b0, nine, lng, 2'b11});
      wr(2'd0, {4'b0, nine, lng, 2'b01});
      wait_ticks(20);
      cmp_cap("R7 R8 single break length");
    end

    // R9 held break bit
    wr(2'd0, 8'h01);
    wait_ticks(2);
    cap_n = 0;
    wr(2'd0, 8'h03);
    wait_ticks(25);
    wr(2'd0, 8'h01);
    wait_ticks(20);
    f = -1; z = 0;
    for (int i = 0; i < cap_n && i < 512; i++) if (f < 0 && cap[i] == 1'b0) f = i;
    if (f >= 0) for (int i = f; i < cap_n && i < 512 && cap[i] == 1'b0; i++) z++;
    chk((z % 10 == 0) && (z >= 20), "R9 held break whole multiples", z, 30);

    // R10 break before queued data
    wr(2'd2, 8'h00);
    cap_n = 0; exp_n = 0;
    push_zeros(10);
    push_frame(1'b0, 9'h0A5);
    align();
    rd(2'd1, d);
    wr(2'd3, 8'hA5);
    wr(2'd0, 8'h03);
    wr(2'd0, 8'h01);
    wait_ticks(30);
    cmp_cap("R10 break ahead of data");

    // R6 preamble in 9-bit mode
    align();
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h09);
    t0 = ticks;
    do rd(2'd1, d); while (!d[6] && ticks < t0 + 40);
    chk(ticks - t0 == 12, "R6 preamble length 9-bit", ticks - t0, 12);

    summary();
    $finish;
  end
endmodule